// File: doc/BRIEF.md
# Logical Device Configuration Register Bank

This block holds the configuration state for every logical device of a plug-and-play expansion card. The card controller drives an 8-bit register index plus write and read strobes. A device-number register chooses which logical device the per-device indices reach. Each device has a set of fields: an enable that puts it on the bus, a conflict-test control, a group of 16-bit I/O base addresses, interrupt level and trigger-mode bytes, and DMA channel selectors. Fields narrower than a byte read back with their unused upper bits as zero.

During the conflict test, the block also answers host I/O reads. Each device that is switched off but has its conflict test enabled decodes an 8-byte window at each of its programmed I/O bases. A read that falls inside that window returns one of two fixed patterns. The host uses this to find address clashes before it enables any device.

A small port sequencer owns the read side and has three states. `PS_IDLE` means no reply is pending. `PS_CFG_REPLY` means configuration read data is valid. `PS_IO_REPLY` means an I/O read reply is valid. From any state, a configuration read strobe leads to `PS_CFG_REPLY`. Failing that, an I/O read strobe leads to `PS_IO_REPLY`. Otherwise the sequencer returns to `PS_IDLE`. Each reply is therefore presented for one cycle, on the cycle after its strobe.

Top module: `ldcfg_bank`

## Requirements
- R1: A write to index 0x07 with a value below the device count selects that logical device, and a read of 0x07 returns the current selection. A write of a value at or above the device count leaves the selection unchanged. Per-device indices read and write only the selected device.
- R2: When built with a single logical device, index 0x07 always reads 0x00 and writes to it have no effect.
- R3: Index 0x30 bit 0 stores the device's bus-enable flag, which is also driven on the matching bit of `dev_active`. Bits 7:1 of 0x30 read as 0.
- R4: In index 0x31, bit 1 is the conflict-test enable and bit 0 is the pattern select. Bits 7:2 read as 0. An enable written while the device is active is stored as 0.
- R5: A write of 1 to bit 0 of 0x30 also clears the conflict-test enable, so a device is never active and under test at the same time.
- R6: I/O base range i uses index 0x60+2i for address bits 15:8 and index 0x61+2i for bits 7:0. All 8 bits are stored.
- R7: Interrupt entry i keeps a 4-bit level at 0x70+2i (bits 7:4 read 0). It keeps a 2-bit mode at 0x71+2i, with bit 1 as polarity and bit 0 as trigger type (bits 7:2 read 0).
- R8: DMA entry i at 0x74+i keeps bits 2:0 as the channel, and bits 7:3 read 0. The value 4 means no channel.
- R9: An I/O read at an address A answers with `io_hit`=1 on the next cycle when some inactive device with conflict test enabled has a base B with B <= A < B+8 (no 16-bit wrap). `io_rdata` is 0x55 if that device's pattern select is 1 and 0xAA if it is 0. The lowest-numbered such device wins. With no match, `io_hit`=0 and `io_rdata`=0x00.
- R10: A `ld_reset` pulse returns every device to inactive, conflict test off, pattern 0, I/O bases 0, interrupt fields 0 and DMA 4, and it keeps the current device selection.
- R11: `rst_n` low gives the same device defaults as R10, sets the selection to 0 and drives `cfg_rvalid`, `io_hit` and `dev_active` low.
- R12: A configuration read strobe gives `cfg_rvalid`=1 and the data on the next cycle. Indices that are not mapped read 0x00. A configuration read has priority over an I/O read in the same cycle, and that I/O read gets no answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_reset | input | 1 | Synchronous reset of all logical devices |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 16 | Host I/O address |
| io_hit | output | 1 | Conflict-test reply valid |
| io_rdata | output | 8 | Conflict-test reply pattern |
| dev_active | output | NDEV | Bus-enable flag of each logical device |

## Verification
The bench targets the following corner cases:
- **Field masks.** Every per-device index is swept with all 256 data values. A mask that is off by one bit shows up as a readback mismatch.
- **Device isolation.** A whole-index sweep of every device after the writes would expose an isolation leak, where a write lands in a device that is not selected.
- **Conflict-test window edges.** The bench sweeps addresses across both window edges, across overlapping windows, and across a base near 0xFFFF. A comparator with a wrong bound would answer one address too many or too few. A comparator that wraps would answer near address 0.
- **Enable/test interlock.** The bench checks the activate and conflict-test interaction in both write orders. It also checks the same-cycle priority between configuration reads and I/O reads.
- **Reset scope.** The bench checks that `ld_reset` keeps the device selection while `rst_n` clears it.

// File: rtl/ldcfg_pkg.sv
package ldcfg_pkg;

    typedef enum logic [1:0] {
        PS_IDLE      = 2'd0,
        PS_CFG_REPLY = 2'd1,
        PS_IO_REPLY  = 2'd2
    } port_state_t;

    localparam logic [7:0] IDX_LDN  = 8'h07;
    localparam logic [7:0] IDX_ACT  = 8'h30;
    localparam logic [7:0] IDX_RCHK = 8'h31;
    localparam logic [7:0] IDX_IOB  = 8'h60;
    localparam logic [7:0] IDX_IRQ  = 8'h70;
    localparam logic [7:0] IDX_DMA  = 8'h74;

    localparam logic [7:0] PAT_55   = 8'h55;
    localparam logic [7:0] PAT_AA   = 8'hAA;
    localparam logic [2:0] DMA_NONE = 3'd4;

endpackage

// File: rtl/ldcfg_dev_regs.sv
module ldcfg_dev_regs
    import ldcfg_pkg::*;
#(
    parameter int NIO  = 2,
    parameter int NIRQ = 2,
    parameter int NDMA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sel,
    input  logic              wr,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              active,
    output logic              rc_en,
    output logic              rc_55,
    output logic [NIO*16-1:0] io_base
);

    logic        act_q, rce_q, r55_q;
    logic [15:0] base_q [NIO];
    logic [3:0]  lvl_q  [NIRQ];
    logic [1:0]  kind_q [NIRQ];
    logic [2:0]  dma_q  [NDMA];
    logic        wr_hit;

    assign wr_hit = wr && sel;

    // enable / conflict-test control with interlock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            rce_q <= 1'b0;
            r55_q <= 1'b0;
        end else if (clr) begin
            act_q <= 1'b0;
            rce_q <= 1'b0;
            r55_q <= 1'b0;
        end else if (wr_hit && idx == IDX_ACT) begin
            act_q <= wdata[0];
            if (wdata[0]) rce_q <= 1'b0;
        end else if (wr_hit && idx == IDX_RCHK) begin
            r55_q <= wdata[0];
            rce_q <= wdata[1] & ~act_q;
        end
    end

    generate
        for (genvar g = 0; g < NIO; g++) begin : g_iob
            localparam logic [7:0] HI_IDX = 8'(IDX_IOB + 2 * g);
            localparam logic [7:0] LO_IDX = 8'(IDX_IOB + 2 * g + 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          base_q[g] <= '0;
                else if (clr)                        base_q[g] <= '0;
                else if (wr_hit && idx == HI_IDX)    base_q[g][15:8] <= wdata;
                else if (wr_hit && idx == LO_IDX)    base_q[g][7:0]  <= wdata;
            end
            assign io_base[g*16 +: 16] = base_q[g];
        end

        for (genvar g = 0; g < NIRQ; g++) begin : g_irq
            localparam logic [7:0] LVL_IDX  = 8'(IDX_IRQ + 2 * g);
            localparam logic [7:0] KIND_IDX = 8'(IDX_IRQ + 2 * g + 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q[g]  <= '0;
                    kind_q[g] <= '0;
                end else if (clr) begin
                    lvl_q[g]  <= '0;
                    kind_q[g] <= '0;
                end else if (wr_hit && idx == LVL_IDX) begin
                    lvl_q[g]  <= wdata[3:0];
                end else if (wr_hit && idx == KIND_IDX) begin
                    kind_q[g] <= wdata[1:0];
                end
            end
        end

        for (genvar g = 0; g < NDMA; g++) begin : g_dma
            localparam logic [7:0] CH_IDX = 8'(IDX_DMA + g);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       dma_q[g] <= DMA_NONE;
                else if (clr)                     dma_q[g] <= DMA_NONE;
                else if (wr_hit && idx == CH_IDX) dma_q[g] <= wdata[2:0];
            end
        end
    endgenerate

    // read-back mux with reserved bits forced to zero
    always_comb begin
        rdata = '0;
        if (idx == IDX_ACT)  rdata = {7'd0, act_q};
        if (idx == IDX_RCHK) rdata = {6'd0, rce_q, r55_q};
        for (int g = 0; g < NIO; g++) begin
            if (idx == 8'(IDX_IOB + 2 * g))     rdata = base_q[g][15:8];
            if (idx == 8'(IDX_IOB + 2 * g + 1)) rdata = base_q[g][7:0];
        end
        for (int g = 0; g < NIRQ; g++) begin
            if (idx == 8'(IDX_IRQ + 2 * g))     rdata = {4'd0, lvl_q[g]};
            if (idx == 8'(IDX_IRQ + 2 * g + 1)) rdata = {6'd0, kind_q[g]};
        end
        for (int g = 0; g < NDMA; g++) begin
            if (idx == 8'(IDX_DMA + g))         rdata = {5'd0, dma_q[g]};
        end
    end

    assign active = act_q;
    assign rc_en  = rce_q;
    assign rc_55  = r55_q;

    // R5: never enabled and under conflict test together
    p_no_dual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_q && rce_q));

    // R4: test enable written while active is dropped
    p_rc_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == IDX_RCHK && act_q && !clr) |=> !rce_q);

    // R3: enable flag follows written bit 0
    p_act_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx == IDX_ACT && !clr) |=> (act_q == $past(wdata[0])));

    // R10: device clear restores defaults
    p_clr_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dma_q[0] == DMA_NONE && !act_q && !rce_q && base_q[0] == 16'd0));

endmodule

// File: rtl/ldcfg_win_match.sv
module ldcfg_win_match #(
    parameter int NIO = 2,
    parameter int WIN = 8
) (
    input  logic [15:0]       io_addr,
    input  logic [NIO*16-1:0] io_base,
    output logic              hit
);

    always_comb begin
        hit = 1'b0;
        for (int g = 0; g < NIO; g++) begin
            if (io_addr >= io_base[g*16 +: 16] &&
                (17'(io_addr) - 17'(io_base[g*16 +: 16])) < 17'(WIN))
                hit = 1'b1;
        end
    end

endmodule

// File: rtl/ldcfg_port_fsm.sv
module ldcfg_port_fsm
    import ldcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_rd,
    input  logic [7:0] cfg_idx,
    input  logic [7:0] rd_data,
    input  logic       io_rd,
    input  logic       io_found,
    input  logic [7:0] io_pat,
    output logic       cfg_rvalid,
    output logic [7:0] cfg_rdata,
    output logic       io_hit,
    output logic [7:0] io_rdata
);

    port_state_t state_q, state_d;
    logic [7:0]  rdata_q, iodata_q, idx_q;
    logic        hit_q;

    always_comb begin
        state_d = PS_IDLE;
        unique case (state_q)
            PS_IDLE, PS_CFG_REPLY, PS_IO_REPLY: begin
                if (cfg_rd)     state_d = PS_CFG_REPLY;
                else if (io_rd) state_d = PS_IO_REPLY;
                else            state_d = PS_IDLE;
            end
            default:            state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            iodata_q <= '0;
            idx_q    <= '0;
            hit_q    <= 1'b0;
        end else begin
            rdata_q  <= (state_d == PS_CFG_REPLY) ? rd_data : 8'd0;
            idx_q    <= cfg_idx;
            hit_q    <= (state_d == PS_IO_REPLY) && io_found;
            iodata_q <= ((state_d == PS_IO_REPLY) && io_found) ? io_pat : 8'd0;
        end
    end

    assign cfg_rvalid = (state_q == PS_CFG_REPLY);
    assign cfg_rdata  = rdata_q;
    assign io_hit     = (state_q == PS_IO_REPLY) && hit_q;
    assign io_rdata   = iodata_q;

    // R12: read reply one cycle after strobe
    p_rd_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);

    // R12: config read wins over a same-cycle I/O read
    p_rd_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && io_rd) |=> !io_hit);

    // R9: only the two fixed patterns appear on a hit
    p_io_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_rdata == PAT_55 || io_rdata == PAT_AA));

    // R3: reserved enable bits read as zero
    p_act_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && idx_q == IDX_ACT) |-> (cfg_rdata[7:1] == 7'd0));

endmodule

// File: rtl/ldcfg_bank.sv
module ldcfg_bank
    import ldcfg_pkg::*;
#(
    parameter int NDEV = 3,
    parameter int NIO  = 2,
    parameter int NIRQ = 2,
    parameter int NDMA = 2,
    parameter int WIN  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_reset,
    input  logic            cfg_wr,
    input  logic            cfg_rd,
    input  logic [7:0]      cfg_idx,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    output logic            cfg_rvalid,
    input  logic            io_rd,
    input  logic [15:0]     io_addr,
    output logic            io_hit,
    output logic [7:0]      io_rdata,
    output logic [NDEV-1:0] dev_active
);

    localparam int LDW = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic [LDW-1:0]    ldn_q;
    logic [7:0]        dev_rdata [NDEV];
    logic [NIO*16-1:0] base_v    [NDEV];
    logic [NDEV-1:0]   act_v, rce_v, r55_v, win_v;
    logic [7:0]        rd_mux, io_pat;
    logic              io_found;

    generate
        if (NDEV > 1) begin : g_ldn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ldn_q <= '0;
                else if (cfg_wr && cfg_idx == IDX_LDN && cfg_wdata < 8'(NDEV))
                    ldn_q <= cfg_wdata[LDW-1:0];
            end

            // R1: legal selection loads
            p_ldn_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_idx == IDX_LDN && cfg_wdata < 8'(NDEV))
                    |=> (ldn_q == $past(cfg_wdata[LDW-1:0])));
            // R10: device reset keeps the selection
            p_ldn_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_reset && !(cfg_wr && cfg_idx == IDX_LDN)) |=> $stable(ldn_q));
        end else begin : g_ldn_fixed
            assign ldn_q = '0;
        end

        for (genvar d = 0; d < NDEV; d++) begin : g_dev
            ldcfg_dev_regs #(
                .NIO  (NIO),
                .NIRQ (NIRQ),
                .NDMA (NDMA)
            ) u_dev (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (ld_reset),
                .sel     (ldn_q == LDW'(d)),
                .wr      (cfg_wr),
                .idx     (cfg_idx),
                .wdata   (cfg_wdata),
                .rdata   (dev_rdata[d]),
                .active  (act_v[d]),
                .rc_en   (rce_v[d]),
                .rc_55   (r55_v[d]),
                .io_base (base_v[d])
            );

            ldcfg_win_match #(
                .NIO (NIO),
                .WIN (WIN)
            ) u_win (
                .io_addr (io_addr),
                .io_base (base_v[d]),
                .hit     (win_v[d])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (cfg_idx == IDX_LDN) begin
            rd_mux = 8'(ldn_q);
        end else begin
            for (int d = 0; d < NDEV; d++)
                if (ldn_q == LDW'(d)) rd_mux = dev_rdata[d];
        end
    end

    // lowest-numbered responding device wins
    always_comb begin
        io_found = 1'b0;
        io_pat   = '0;
        for (int d = NDEV - 1; d >= 0; d--) begin
            if (win_v[d] && rce_v[d] && !act_v[d]) begin
                io_found = 1'b1;
                io_pat   = r55_v[d] ? PAT_55 : PAT_AA;
            end
        end
    end

    ldcfg_port_fsm u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_rd     (cfg_rd),
        .cfg_idx    (cfg_idx),
        .rd_data    (rd_mux),
        .io_rd      (io_rd),
        .io_found   (io_found),
        .io_pat     (io_pat),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata),
        .io_hit     (io_hit),
        .io_rdata   (io_rdata)
    );

    assign dev_active = act_v;

endmodule

// File: tb/ldcfg_bank_bench.sv
module ldcfg_bank_bench;

    localparam int NDEV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_reset = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  cfg_rdata, io_rdata, s_rdata, s_iordata;
    logic        cfg_rvalid, io_hit, s_rvalid, s_iohit;
    logic [NDEV-1:0] dev_active;
    logic [0:0]  s_active;

    int n_chk = 0;
    int n_fail = 0;
    int ldn_m = 0;
    logic [7:0] sh [NDEV][256];

    always #2 clk = ~clk;

    ldcfg_bank u_ldcfg_bank (
        .clk(clk), .rst_n(rst_n), .ld_reset(ld_reset),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .io_rd(io_rd), .io_addr(io_addr), .io_hit(io_hit), .io_rdata(io_rdata),
        .dev_active(dev_active)
    );

    ldcfg_bank #(.NDEV(1)) u_ldcfg_bank_single (
        .clk(clk), .rst_n(rst_n), .ld_reset(ld_reset),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(s_rdata), .cfg_rvalid(s_rvalid),
        .io_rd(io_rd), .io_addr(io_addr), .io_hit(s_iohit), .io_rdata(s_iordata),
        .dev_active(s_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(input int idx);
        return (idx == 8'h30 || idx == 8'h31 || (idx >= 8'h60 && idx <= 8'h63) ||
                (idx >= 8'h70 && idx <= 8'h75));
    endfunction

    function automatic string req_of(input int idx);
        if (idx == 8'h30) return "R3";
        if (idx == 8'h31) return "R4";
        if (idx >= 8'h60 && idx <= 8'h63) return "R6";
        if (idx >= 8'h70 && idx <= 8'h73) return "R7";
        if (idx >= 8'h74 && idx <= 8'h75) return "R8";
        return "R12";
    endfunction

    function automatic logic [7:0] mask_of(input int idx, input logic [7:0] v);
        if (idx >= 8'h60 && idx <= 8'h63) return v;
        if (idx == 8'h70 || idx == 8'h72) return v & 8'h0F;
        if (idx == 8'h71 || idx == 8'h73) return v & 8'h03;
        if (idx == 8'h74 || idx == 8'h75) return v & 8'h07;
        return 8'h00;
    endfunction

    task automatic model_defaults(input bit keep_ldn);
        for (int d = 0; d < NDEV; d++) begin
            for (int i = 0; i < 256; i++) sh[d][i] = 8'h00;
            sh[d][8'h74] = 8'h04;
            sh[d][8'h75] = 8'h04;
        end
        if (!keep_ldn) ldn_m = 0;
    endtask

    task automatic wr(input int idx, input int v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 8'(idx); cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (idx == 8'h07) begin
            if (v < NDEV) ldn_m = v;
        end else if (idx == 8'h30) begin
            sh[ldn_m][8'h30] = 8'(v & 1);
            if (v & 1) sh[ldn_m][8'h31] = sh[ldn_m][8'h31] & 8'h01;
        end else if (idx == 8'h31) begin
            sh[ldn_m][8'h31] = sh[ldn_m][8'h30][0] ? 8'(v & 1) : 8'(v & 3);
        end else if (is_mapped(idx)) begin
            sh[ldn_m][idx] = mask_of(idx, 8'(v));
        end
    endtask

    task automatic rd_chk(input int idx, input string req);
        logic [7:0] exp;
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = 8'(idx);
        @(negedge clk);
        cfg_rd = 1'b0;
        exp = (idx == 8'h07) ? 8'(ldn_m) : sh[ldn_m][idx];
        check(cfg_rvalid === 1'b1 && cfg_rdata === exp, req, int'(cfg_rdata), int'(exp));
    endtask

    task automatic sweep_all(input string req);
        for (int d = 0; d < NDEV; d++) begin
            wr(8'h07, d);
            for (int i = 0; i < 256; i++) rd_chk(i, req);
        end
    endtask

    task automatic io_chk(input int addr, input string req);
        bit found;
        logic [7:0] pat;
        int b;
        found = 1'b0; pat = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (!found && sh[d][8'h31][1] && !sh[d][8'h30][0]) begin
                for (int r = 0; r < 2; r++) begin
                    b = {sh[d][8'h60 + 2*r], sh[d][8'h61 + 2*r]};
                    if (!found && addr >= b && addr < b + 8) begin
                        found = 1'b1;
                        pat = sh[d][8'h31][0] ? 8'h55 : 8'hAA;
                    end
                end
            end
        end
        @(negedge clk);
        io_rd = 1'b1; io_addr = 16'(addr);
        @(negedge clk);
        io_rd = 1'b0;
        check(io_hit === found && io_rdata === pat, req,
              int'({io_hit, io_rdata}), int'({found, pat}));
    endtask

    task automatic check_active(input string req);
        logic [NDEV-1:0] e;
        for (int d = 0; d < NDEV; d++) e[d] = sh[d][8'h30][0];
        check(dev_active === e, req, int'(dev_active), int'(e));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_defaults(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state at the ports
        check(cfg_rvalid === 1'b0, "R11", int'(cfg_rvalid), 0);
        check(io_hit === 1'b0, "R11", int'(io_hit), 0);
        check(dev_active === '0, "R11", int'(dev_active), 0);
        rd_chk(8'h07, "R11");
        sweep_all("R11");

        // R1: selection, out-of-range ignored; R2: single-device LDN
        wr(8'h07, 2); rd_chk(8'h07, "R1");
        check(s_rvalid === 1'b1 && s_rdata === 8'h00, "R2", int'(s_rdata), 0);
        wr(8'h07, 3); rd_chk(8'h07, "R1");
        wr(8'h07, 255); rd_chk(8'h07, "R1");
        check(s_rdata === 8'h00, "R2", int'(s_rdata), 0);
        wr(8'h07, 1); rd_chk(8'h07, "R1");
        check(s_rdata === 8'h00, "R2", int'(s_rdata), 0);

        // full-value sweeps of every field on every device
        for (int d = 0; d < NDEV; d++) begin
            wr(8'h07, d);
            for (int k = 0; k < 13; k++) begin
                int idx;
                idx = (k == 0) ? 8'h31 : (k == 12) ? 8'h30 :
                      (k <= 4) ? (8'h60 + k - 1) : (8'h70 + k - 5);
                for (int v = 0; v < 256; v++) begin
                    wr(idx, v);
                    rd_chk(idx, req_of(idx));
                    if (idx == 8'h30 && v < 4) check_active("R3");
                end
            end
        end
        // R1: no leak between devices
        sweep_all("R1");

        // R4: enable written while active is dropped
        wr(8'h07, 0);
        wr(8'h30, 1); wr(8'h31, 3); rd_chk(8'h31, "R4");
        // R5: activate clears a pending test enable
        wr(8'h30, 0); wr(8'h31, 2); rd_chk(8'h31, "R5");
        wr(8'h30, 1); rd_chk(8'h31, "R5"); rd_chk(8'h30, "R5");
        check_active("R5");

        // R9: conflict-test windows
        for (int d = 0; d < NDEV; d++) begin
            wr(8'h07, d); wr(8'h30, 0); wr(8'h31, 0);
            wr(8'h60, 8'h10); wr(8'h61, 8'h00); wr(8'h62, 8'h10); wr(8'h63, 8'h00);
        end
        wr(8'h07, 1);
        wr(8'h60, 8'h03); wr(8'h61, 8'h00); wr(8'h62, 8'h03); wr(8'h63, 8'h80); wr(8'h31, 3);
        wr(8'h07, 2);
        wr(8'h60, 8'h03); wr(8'h61, 8'h04); wr(8'h31, 2);
        for (int a = 16'h02F0; a < 16'h0392; a++) io_chk(a, "R9");
        wr(8'h07, 0);
        wr(8'h60, 8'hFF); wr(8'h61, 8'hFC); wr(8'h31, 2);
        for (int a = 16'hFFF0; a <= 16'hFFFF; a++) io_chk(a, "R9");
        for (int a = 0; a < 16'h10; a++) io_chk(a, "R9");
        // R5/R9: active device stops answering
        wr(8'h07, 1); wr(8'h30, 1);
        for (int a = 16'h02FC; a < 16'h030E; a++) io_chk(a, "R9");

        // R12: config read wins over same-cycle I/O read
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = 8'h07; io_rd = 1'b1; io_addr = 16'h0305;
        @(negedge clk);
        cfg_rd = 1'b0; io_rd = 1'b0;
        check(cfg_rvalid === 1'b1 && cfg_rdata === 8'(ldn_m), "R12", int'(cfg_rdata), ldn_m);
        check(io_hit === 1'b0, "R12", int'(io_hit), 0);
        io_chk(16'h0305, "R12");

        // R10: device reset keeps selection
        @(negedge clk); ld_reset = 1'b1;
        @(negedge clk); ld_reset = 1'b0;
        model_defaults(1'b1);
        check_active("R10");
        rd_chk(8'h07, "R10");
        sweep_all("R10");
        io_chk(16'h0000, "R10");

        // R11: full reset clears selection
        wr(8'h07, 2); wr(8'h30, 1); wr(8'h74, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_defaults(1'b0);
        check(dev_active === '0, "R11", int'(dev_active), 0);
        rd_chk(8'h07, "R11");
        rd_chk(8'h74, "R11");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule